// File: doc/BRIEF.md
# Polled Console Character Output Port

This block sits on a 16-bit processor memory bus and gives software a way to send characters to a display or serial back end by polling. It answers at two fixed word addresses: a read-only status word and a character data word. Software reads the status word and loops until its top bit is set. Because that bit is the sign bit, a single sign-based branch can test it. Software then writes a character to the data word. The block keeps the low byte of that word and offers it on a byte stream with a valid/ready handshake. The status bit stays clear until the back end takes the byte.

The control logic is a two-state machine. In `ST_READY` the port is idle, reports ready in the status word and accepts a character write. The transition *launch* (a data-word write while in `ST_READY`) moves it to `ST_BUSY`. In `ST_BUSY` the byte is offered downstream and further data writes are dropped. The transition *drain* (downstream valid and ready both high at a clock edge) returns it to `ST_READY`. Bus reads are combinational and come back in the same cycle they are asserted. A separate hit flag marks when this block is the one supplying read data.

Top module: `conout_port`

## Requirements
- R1: After reset the state is `ST_READY`: `out_valid` is 0, status bit 15 reads 1, and the data word reads 0x0000.
- R2: A read of address 0xF3FC returns a word with bit 15 equal to the ready flag (1 in `ST_READY`, 0 in `ST_BUSY`) and bits 14:0 zero. It raises `bus_rhit` in the same cycle.
- R3: A write to address 0xF3FF in `ST_READY` raises `out_valid` after the next clock edge, with `out_byte` equal to the written bits 7:0. Status bit 15 reads 0 from that point.
- R4: In `ST_BUSY` with `out_ready` low, `out_valid` stays high and `out_byte` stays unchanged.
- R5: In `ST_BUSY`, a clock edge with `out_ready` high returns the block to `ST_READY`: `out_valid` is 0 and status bit 15 reads 1 after that edge.
- R6: A write to 0xF3FF in `ST_BUSY` is ignored: `out_byte` and the data word keep the earlier character, and the block stays busy.
- R7: A read of 0xF3FF returns the last accepted character in bits 7:0 with bits 15:8 zero, and raises `bus_rhit`.
- R8: Any access to an address other than 0xF3FC and 0xF3FF leaves `bus_rhit` low and `bus_rdata` zero, and a write there changes nothing.
- R9: Bits 15:8 of a word written to the data address are discarded.
- R10: The status word is read-only: a write to 0xF3FC changes neither state nor character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Bus word address |
| bus_wdata | input | 16 | Bus write data |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rdata | output | 16 | Read data, zero when not hit |
| bus_rhit | output | 1 | This block is supplying read data this cycle |
| out_byte | output | 8 | Character offered downstream |
| out_valid | output | 1 | Character valid toward the back end |
| out_ready | input | 1 | Back end accepts the character |

## Verification
On every cycle the assertions check the following: the launch and drain transitions, that the byte stays stable while the back end stalls, that a write in `ST_BUSY` is dropped, and the shape of status, data and foreign-address reads. The scenarios alone show the effects that take more than one step to observe. Examples are the data word echoing the character only after a launch, a status write leaving the port untouched, a foreign write not starting a transfer, and a reset taken in the middle of a transfer returning the port to ready with the character cleared.

// File: rtl/conout_pkg.sv
package conout_pkg;

    typedef enum logic [0:0] {
        ST_READY = 1'b0,
        ST_BUSY  = 1'b1
    } conout_state_e;

    typedef struct packed {
        logic stat_rd;
        logic data_rd;
        logic data_wr;
    } conout_sel_t;

endpackage

// File: rtl/conout_decode.sv
module conout_decode
    import conout_pkg::*;
#(
    parameter int unsigned          ADDR_W    = 16,
    parameter logic [ADDR_W-1:0]    STAT_ADDR = 16'hF3FC,
    parameter logic [ADDR_W-1:0]    DATA_ADDR = 16'hF3FF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output conout_sel_t       sel
);

    logic stat_match;
    logic data_match;

    always_comb begin
        stat_match  = (addr == STAT_ADDR);
        data_match  = (addr == DATA_ADDR);
        sel.stat_rd = rd && stat_match;
        sel.data_rd = rd && data_match;
        // the status word has no writable state
        sel.data_wr = wr && data_match;
    end

endmodule

// File: rtl/conout_fsm.sv
module conout_fsm
    import conout_pkg::*;
#(
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr,
    input  logic [CHAR_W-1:0] wchar,
    input  logic              snk_rdy,
    output logic              ready,
    output logic              src_vld,
    output logic [CHAR_W-1:0] char_q
);

    conout_state_e state_q;
    conout_state_e state_d;
    logic          launch;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_READY;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: launch (READY->BUSY), drain (BUSY->READY)
    always_comb begin
        state_d = state_q;
        launch  = 1'b0;
        unique case (state_q)
            ST_READY: begin
                if (data_wr) begin
                    launch  = 1'b1;
                    state_d = ST_BUSY;
                end
            end
            ST_BUSY: begin
                if (snk_rdy) begin
                    state_d = ST_READY;
                end
            end
            default: state_d = ST_READY;
        endcase
    end

    // character holding register, loaded only on launch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            char_q <= '0;
        end else if (launch) begin
            char_q <= wchar;
        end
    end

    // outputs
    always_comb begin
        ready   = 1'b0;
        src_vld = 1'b0;
        unique case (state_q)
            ST_READY: ready   = 1'b1;
            ST_BUSY:  src_vld = 1'b1;
            default:  ready   = 1'b0;
        endcase
    end

endmodule

// File: rtl/conout_rdmux.sv
module conout_rdmux
    import conout_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CHAR_W = 8
) (
    input  conout_sel_t       sel,
    input  logic              ready,
    input  logic [CHAR_W-1:0] char_q,
    output logic [DATA_W-1:0] rdata,
    output logic              rhit
);

    localparam int unsigned RDY_BIT = DATA_W - 1;

    always_comb begin
        rdata = '0;
        rhit  = sel.stat_rd || sel.data_rd;
        if (sel.stat_rd) begin
            rdata[RDY_BIT] = ready;
        end
        if (sel.data_rd) begin
            rdata[CHAR_W-1:0] = char_q;
        end
    end

endmodule

// File: rtl/conout_port.sv
module conout_port
    import conout_pkg::*;
#(
    parameter int unsigned          ADDR_W    = 16,
    parameter int unsigned          DATA_W    = 16,
    parameter int unsigned          CHAR_W    = 8,
    parameter logic [ADDR_W-1:0]    STAT_ADDR = 16'hF3FC,
    parameter logic [ADDR_W-1:0]    DATA_ADDR = 16'hF3FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rhit,
    output logic [CHAR_W-1:0] out_byte,
    output logic              out_valid,
    input  logic              out_ready
);

    conout_sel_t sel;
    logic        ready;

    conout_decode #(
        .ADDR_W    (ADDR_W),
        .STAT_ADDR (STAT_ADDR),
        .DATA_ADDR (DATA_ADDR)
    ) u_decode (
        .addr (bus_addr),
        .rd   (bus_rd),
        .wr   (bus_wr),
        .sel  (sel)
    );

    conout_fsm #(
        .CHAR_W (CHAR_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_wr (sel.data_wr),
        .wchar   (bus_wdata[CHAR_W-1:0]),
        .snk_rdy (out_ready),
        .ready   (ready),
        .src_vld (out_valid),
        .char_q  (out_byte)
    );

    conout_rdmux #(
        .DATA_W (DATA_W),
        .CHAR_W (CHAR_W)
    ) u_rdmux (
        .sel    (sel),
        .ready  (ready),
        .char_q (out_byte),
        .rdata  (bus_rdata),
        .rhit   (bus_rhit)
    );

endmodule

// File: rtl/conout_port_chk.sv
module conout_port_chk #(
    parameter int unsigned          ADDR_W    = 16,
    parameter int unsigned          DATA_W    = 16,
    parameter int unsigned          CHAR_W    = 8,
    parameter logic [ADDR_W-1:0]    STAT_ADDR = 16'hF3FC,
    parameter logic [ADDR_W-1:0]    DATA_ADDR = 16'hF3FF
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_rhit,
    input logic [CHAR_W-1:0] out_byte,
    input logic              out_valid,
    input logic              out_ready
);

    a_r3_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == DATA_ADDR && !out_valid)
        |=> (out_valid && out_byte == $past(bus_wdata[CHAR_W-1:0])));

    a_r4_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));

    a_r5_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> !out_valid);

    a_r6_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && bus_wr && bus_addr == DATA_ADDR) |=> $stable(out_byte));

    a_r2_status_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == STAT_ADDR)
        |-> (bus_rhit && bus_rdata[DATA_W-2:0] == '0 && bus_rdata[DATA_W-1] == !out_valid));

    a_r7_data_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == DATA_ADDR)
        |-> (bus_rhit && bus_rdata[DATA_W-1:CHAR_W] == '0 && bus_rdata[CHAR_W-1:0] == out_byte));

    a_r8_foreign: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd || (bus_addr != STAT_ADDR && bus_addr != DATA_ADDR))
        |-> (!bus_rhit && bus_rdata == '0));

endmodule

bind conout_port conout_port_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CHAR_W    (CHAR_W),
    .STAT_ADDR (STAT_ADDR),
    .DATA_ADDR (DATA_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .bus_rhit  (bus_rhit),
    .out_byte  (out_byte),
    .out_valid (out_valid),
    .out_ready (out_ready)
);

// File: tb/conout_port_test.sv
module conout_port_test;

    localparam logic [1:0] OP_IDLE = 2'd0;
    localparam logic [1:0] OP_RD   = 2'd1;
    localparam logic [1:0] OP_WR   = 2'd2;
    localparam logic [15:0] A_STAT = 16'hF3FC;
    localparam logic [15:0] A_DATA = 16'hF3FF;

    typedef struct packed {
        logic [1:0]  op;
        logic [15:0] addr;
        logic [15:0] wdata;
        logic        snk;
        logic [15:0] exp_rd;
        logic        exp_hit;
        logic        exp_vld;
        logic [7:0]  exp_byte;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VECS [NVEC] = '{
        '{OP_RD,   A_STAT,     16'h0000, 1'b0, 16'h8000, 1'b1, 1'b0, 8'h00, 8'd2},  // R2 idle status
        '{OP_RD,   A_DATA,     16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 8'h00, 8'd7},  // R7 empty data
        '{OP_WR,   A_DATA,     16'h1241, 1'b0, 16'h0000, 1'b0, 1'b1, 8'h41, 8'd3},  // R3 launch, R9
        '{OP_RD,   A_STAT,     16'h0000, 1'b0, 16'h0000, 1'b1, 1'b1, 8'h41, 8'd4},  // R4 busy stall
        '{OP_WR,   A_DATA,     16'h0055, 1'b0, 16'h0000, 1'b0, 1'b1, 8'h41, 8'd6},  // R6 dropped
        '{OP_RD,   A_DATA,     16'h0000, 1'b0, 16'h0041, 1'b1, 1'b1, 8'h41, 8'd6},  // R6 data kept
        '{OP_IDLE, 16'h0000,   16'h0000, 1'b1, 16'h0000, 1'b0, 1'b0, 8'h41, 8'd5},  // R5 drain
        '{OP_RD,   A_STAT,     16'h0000, 1'b0, 16'h8000, 1'b1, 1'b0, 8'h41, 8'd5},  // R5 ready again
        '{OP_RD,   16'h1234,   16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0, 8'h41, 8'd8},  // R8 foreign read
        '{OP_WR,   16'hF3FD,   16'h0077, 1'b0, 16'h0000, 1'b0, 1'b0, 8'h41, 8'd8},  // R8 foreign write
        '{OP_WR,   A_STAT,     16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0, 8'h41, 8'd10}, // R10 status write
        '{OP_RD,   A_STAT,     16'h0000, 1'b0, 16'h8000, 1'b1, 1'b0, 8'h41, 8'd10}, // R10 still ready
        '{OP_WR,   A_DATA,     16'hFF80, 1'b1, 16'h0000, 1'b0, 1'b1, 8'h80, 8'd9},  // R9 high byte dropped
        '{OP_IDLE, 16'h0000,   16'h0000, 1'b1, 16'h0000, 1'b0, 1'b0, 8'h80, 8'd5},  // R5 one-cycle drain
        '{OP_RD,   A_DATA,     16'h0000, 1'b0, 16'h0080, 1'b1, 1'b0, 8'h80, 8'd9}   // R9 echo
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_rdata;
    logic        bus_rhit;
    logic [7:0]  out_byte;
    logic        out_valid;
    logic        out_ready = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    conout_port uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_rdata (bus_rdata),
        .bus_rhit  (bus_rhit),
        .out_byte  (out_byte),
        .out_valid (out_valid),
        .out_ready (out_ready)
    );

    task automatic check(input int req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] op, input logic [15:0] a,
                         input logic [15:0] d, input logic snk);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_rd    = (op == OP_RD);
        bus_wr    = (op == OP_WR);
        out_ready = snk;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check(1, "out_valid after reset", {15'b0, out_valid}, 16'h0000);
        drive(OP_RD, A_STAT, 16'h0, 1'b0);
        #1 check(1, "status after reset", bus_rdata, 16'h8000);
        drive(OP_RD, A_DATA, 16'h0, 1'b0);
        #1 check(1, "data after reset", bus_rdata, 16'h0000);

        for (int i = 0; i < NVEC; i++) begin
            drive(VECS[i].op, VECS[i].addr, VECS[i].wdata, VECS[i].snk);
            #1;
            check(int'(VECS[i].req), $sformatf("vec %0d rdata", i), bus_rdata, VECS[i].exp_rd);
            check(int'(VECS[i].req), $sformatf("vec %0d rhit", i), {15'b0, bus_rhit}, {15'b0, VECS[i].exp_hit});
            @(posedge clk);
            #1;
            check(int'(VECS[i].req), $sformatf("vec %0d out_valid", i), {15'b0, out_valid}, {15'b0, VECS[i].exp_vld});
            check(int'(VECS[i].req), $sformatf("vec %0d out_byte", i), {8'b0, out_byte}, {8'b0, VECS[i].exp_byte});
        end

        // R4 long stall: byte held over many cycles
        drive(OP_WR, A_DATA, 16'h005A, 1'b0);
        drive(OP_IDLE, 16'h0, 16'h0, 1'b0);
        repeat (20) @(negedge clk);
        #1 check(4, "long stall valid", {15'b0, out_valid}, 16'h0001);
        check(4, "long stall byte", {8'b0, out_byte}, 16'h005A);

        // R1 reset in the middle of a transfer
        @(negedge clk);
        rst_n = 1'b0;
        #1 check(1, "valid during reset", {15'b0, out_valid}, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        drive(OP_RD, A_STAT, 16'h0, 1'b0);
        #1 check(1, "status after mid reset", bus_rdata, 16'h8000);
        drive(OP_RD, A_DATA, 16'h0, 1'b0);
        #1 check(1, "data after mid reset", bus_rdata, 16'h0000);
        drive(OP_IDLE, 16'h0, 16'h0, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule